// File: doc/BRIEF.md
# Preamble/Postamble Framing Sequence Tracker

This block follows the framing of one recorded tape block through four status bits. A phase-lock window opens when the block-pattern detector reports a block while phase synchronisation is running. Inside that window the block records the first data byte, which marks the end of the preamble. It then records the last data byte, which marks the head of the postamble. After that it counts cell-clock enables until a delay has passed. The delay depends on the recording density and on the direction. When the count completes, the block raises the end-of-postamble flag, and that flag closes the window.

The sequence runs only in the two high-density modes. In the low-density mode none of the bits ever sets. Each status bit has its own clear condition. All outputs are registered and a synchronous clear input resets every state.

Top module: `framing_seq_tracker`

## Requirements
- R1: When `blockSeen`, `phaseStart` and a valid mode are all present at a clock edge, `phaseOk` is 1 after that edge. A valid mode is `modeHi`=1 (6250 density) or `modeHi`=0 with `modeMid`=1 (1600 density).
- R2: `phaseOk` goes to 0 at the edge after `phaseStart` is sampled low. It also goes to 0 at the edge after `endOfPost` rises.
- R3: `firstByte` sets `preambleSeen` and `lastByte` sets `postambleSeen`, but only while `phaseOk` is 1. A strobe that arrives while `phaseOk` is 0 is ignored. Both flags go to 0 at the edge after `phaseOk` is 0, and they stay 0 while `phaseOk` stays 0.
- R4: `endOfPost` rises at the edge that samples the D-th `cellTick` after `postambleSeen` became 1. A tick sampled at the edge that sets `postambleSeen` is not counted. D depends on `modeHi` and `writeDir` (1 = write):
  - 6250 density: D = 34 for write, 6 for read.
  - 1600 density: D = 31 for write, 21 for read.
- R5: Only cycles with `cellTick`=1 advance the delay count. Idle cycles between ticks do not change the result.
- R6: A rising edge on `endClr` clears `endOfPost` at the next clock edge. It does not restart the delay while `postambleSeen` stays high.
- R7: While `cycleEn` is 0, `endOfPost` is 0 after every edge.
- R8: With `modeHi`=0 and `modeMid`=0 (low-density mode), `phaseOk` never sets, so no other status bit sets.
- R9: `syncClear` forces every output to 0 at the next edge. After reset every output is 0.
- R10: If the rising edge of `endClr` falls in the same cycle as the final counting tick, the clear wins. `endOfPost` stays 0, and later ticks do not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| syncClear | input | 1 | Synchronous clear of all state |
| modeHi | input | 1 | Selects 6250 density |
| modeMid | input | 1 | Selects 1600 density (used when modeHi=0) |
| writeDir | input | 1 | 1 = write, 0 = read |
| cycleEn | input | 1 | Machine-cycle enable |
| phaseStart | input | 1 | Phase synchronisation running |
| blockSeen | input | 1 | Block pattern detected |
| firstByte | input | 1 | First data byte strobe |
| lastByte | input | 1 | Last data byte strobe |
| cellTick | input | 1 | One bit-cell enable |
| endClr | input | 1 | End-of-postamble clear (rising edge acts) |
| phaseOk | output | 1 | Phase-lock window open |
| preambleSeen | output | 1 | First data byte seen |
| postambleSeen | output | 1 | Last data byte seen |
| endOfPost | output | 1 | Postamble length confirmed |

## Verification
Two functions can fall in the same cycle: completion of the postamble delay and the clear edge on `endClr`. The bench provokes this by raising `endClr` in exactly the cycle that carries the final counting tick. It judges the result by checking that `endOfPost` stays 0 and that `phaseOk` stays open. It then sends further ticks and checks that the counter does not re-arm. Separately, the bench sweeps all four density and direction combinations and computes the tick index where `endOfPost` must rise from the mode. It checks that the flag is still low one tick earlier.

// File: rtl/framing_seq_pkg.sv
package framing_seq_pkg;

  typedef struct packed {
    logic countEn;
    logic countClr;
  } seqStrobe_t;

  function automatic int unsigned pickDelay(
    input logic hi, input logic wr,
    input int unsigned hiWr, input int unsigned hiRd,
    input int unsigned midWr, input int unsigned midRd);
    if (hi) return wr ? hiWr : hiRd;
    return wr ? midWr : midRd;
  endfunction

endpackage

// File: rtl/framing_seq_count.sv
module framing_seq_count
  import framing_seq_pkg::*;
#(
  parameter int unsigned HI_WR  = 34,
  parameter int unsigned HI_RD  = 6,
  parameter int unsigned MID_WR = 31,
  parameter int unsigned MID_RD = 21,
  localparam int unsigned MAX_A = (HI_WR > HI_RD) ? HI_WR : HI_RD,
  localparam int unsigned MAX_B = (MID_WR > MID_RD) ? MID_WR : MID_RD,
  localparam int unsigned MAX_D = (MAX_A > MAX_B) ? MAX_A : MAX_B,
  localparam int unsigned CNT_W = $clog2(MAX_D + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       syncClear,
  input  logic       modeHi,
  input  logic       writeDir,
  input  logic       cellTick,
  input  seqStrobe_t strobes,
  output logic       delayDone
);

  logic [CNT_W-1:0] cellCnt;
  logic [CNT_W-1:0] limitM1;

  always_comb begin
    limitM1 = CNT_W'(pickDelay(modeHi, writeDir, HI_WR, HI_RD, MID_WR, MID_RD) - 1);
  end

  assign delayDone = strobes.countEn && cellTick && (cellCnt == limitM1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cellCnt <= '0;
    end else if (syncClear || strobes.countClr) begin
      cellCnt <= '0;
    end else if (strobes.countEn && cellTick && !delayDone) begin
      cellCnt <= cellCnt + 1'b1;
    end
  end

  // R4: the count never passes the selected limit
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    cellCnt <= CNT_W'(MAX_D));

  // R5: without a tick the count does not move
  a_r5_hold_no_tick: assert property (@(posedge clk) disable iff (!rstN)
    (!cellTick && !syncClear && !strobes.countClr) |=> $stable(cellCnt));

endmodule

// File: rtl/framing_seq_ctrl.sv
module framing_seq_ctrl
  import framing_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       syncClear,
  input  logic       modeOk,
  input  logic       cycleEn,
  input  logic       phaseStart,
  input  logic       blockSeen,
  input  logic       firstByte,
  input  logic       lastByte,
  input  logic       endClr,
  input  logic       delayDone,
  output seqStrobe_t strobes,
  output logic       phaseOk,
  output logic       preambleSeen,
  output logic       postambleSeen,
  output logic       endOfPost
);

  logic endPrev;
  logic clrPrev;
  logic fired;
  logic endRise;
  logic clrRise;

  assign endRise = endOfPost && !endPrev;
  assign clrRise = endClr && !clrPrev;
  assign strobes.countEn  = postambleSeen && !fired;
  assign strobes.countClr = !postambleSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseOk       <= 1'b0;
      preambleSeen  <= 1'b0;
      postambleSeen <= 1'b0;
      endOfPost     <= 1'b0;
      endPrev       <= 1'b0;
      clrPrev       <= 1'b0;
      fired         <= 1'b0;
    end else if (syncClear) begin
      phaseOk       <= 1'b0;
      preambleSeen  <= 1'b0;
      postambleSeen <= 1'b0;
      endOfPost     <= 1'b0;
      endPrev       <= 1'b0;
      clrPrev       <= 1'b0;
      fired         <= 1'b0;
    end else begin
      endPrev <= endOfPost;
      clrPrev <= endClr;

      if (!phaseStart || endRise)           phaseOk <= 1'b0;
      else if (blockSeen && modeOk)         phaseOk <= 1'b1;

      if (!phaseOk)                         preambleSeen <= 1'b0;
      else if (firstByte)                   preambleSeen <= 1'b1;

      if (!phaseOk)                         postambleSeen <= 1'b0;
      else if (lastByte)                    postambleSeen <= 1'b1;

      if (!postambleSeen)                   fired <= 1'b0;
      else if (delayDone)                   fired <= 1'b1;

      if (!cycleEn || clrRise)              endOfPost <= 1'b0;
      else if (delayDone)                   endOfPost <= 1'b1;
    end
  end

  // R1: phaseOk only opens on a block report with phase sync running
  a_r1_phase_open: assert property (@(posedge clk) disable iff (!rstN)
    $rose(phaseOk) |-> $past(blockSeen && phaseStart));
  // R2: releasing phase sync closes the window
  a_r2_phase_close: assert property (@(posedge clk) disable iff (!rstN)
    !phaseStart |=> !phaseOk);
  // R3: flags are zero following a closed window
  a_r3_pre_gated: assert property (@(posedge clk) disable iff (!rstN)
    !phaseOk |=> !preambleSeen);
  a_r3_post_gated: assert property (@(posedge clk) disable iff (!rstN)
    !phaseOk |=> !postambleSeen);
  // R4: end-of-postamble only rises behind the postamble flag
  a_r4_end_after_post: assert property (@(posedge clk) disable iff (!rstN)
    $rose(endOfPost) |-> $past(postambleSeen));
  // R7: machine cycle off keeps end-of-postamble low
  a_r7_cycle_gate: assert property (@(posedge clk) disable iff (!rstN)
    !cycleEn |=> !endOfPost);
  // R8: low-density mode never opens the window
  a_r8_low_density: assert property (@(posedge clk) disable iff (!rstN)
    (!modeOk && !phaseOk) |=> !phaseOk);

endmodule

// File: rtl/framing_seq_tracker.sv
module framing_seq_tracker
  import framing_seq_pkg::*;
#(
  parameter int unsigned HI_WR  = 34,
  parameter int unsigned HI_RD  = 6,
  parameter int unsigned MID_WR = 31,
  parameter int unsigned MID_RD = 21
) (
  input  logic clk,
  input  logic rstN,
  input  logic syncClear,
  input  logic modeHi,
  input  logic modeMid,
  input  logic writeDir,
  input  logic cycleEn,
  input  logic phaseStart,
  input  logic blockSeen,
  input  logic firstByte,
  input  logic lastByte,
  input  logic cellTick,
  input  logic endClr,
  output logic phaseOk,
  output logic preambleSeen,
  output logic postambleSeen,
  output logic endOfPost
);

  seqStrobe_t strobes;
  logic       delayDone;
  logic       modeOk;

  assign modeOk = modeHi || modeMid;

  framing_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .syncClear(syncClear), .modeOk(modeOk),
    .cycleEn(cycleEn), .phaseStart(phaseStart), .blockSeen(blockSeen),
    .firstByte(firstByte), .lastByte(lastByte), .endClr(endClr),
    .delayDone(delayDone), .strobes(strobes), .phaseOk(phaseOk),
    .preambleSeen(preambleSeen), .postambleSeen(postambleSeen),
    .endOfPost(endOfPost)
  );

  framing_seq_count #(
    .HI_WR(HI_WR), .HI_RD(HI_RD), .MID_WR(MID_WR), .MID_RD(MID_RD)
  ) u_count (
    .clk(clk), .rstN(rstN), .syncClear(syncClear), .modeHi(modeHi),
    .writeDir(writeDir), .cellTick(cellTick), .strobes(strobes),
    .delayDone(delayDone)
  );

  // R9: synchronous clear empties every flag
  a_r9_sync_clear: assert property (@(posedge clk) disable iff (!rstN)
    syncClear |=> !(phaseOk || preambleSeen || postambleSeen || endOfPost));

endmodule

// File: tb/framing_seq_tracker_tb.sv
module framing_seq_tracker_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic syncClear = 1'b0, modeHi = 1'b0, modeMid = 1'b0, writeDir = 1'b0;
  logic cycleEn = 1'b0, phaseStart = 1'b0, blockSeen = 1'b0;
  logic firstByte = 1'b0, lastByte = 1'b0, cellTick = 1'b0, endClr = 1'b0;
  logic phaseOk, preambleSeen, postambleSeen, endOfPost;

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  framing_seq_tracker u_dut (
    .clk(clk), .rstN(rstN), .syncClear(syncClear), .modeHi(modeHi),
    .modeMid(modeMid), .writeDir(writeDir), .cycleEn(cycleEn),
    .phaseStart(phaseStart), .blockSeen(blockSeen), .firstByte(firstByte),
    .lastByte(lastByte), .cellTick(cellTick), .endClr(endClr),
    .phaseOk(phaseOk), .preambleSeen(preambleSeen),
    .postambleSeen(postambleSeen), .endOfPost(endOfPost)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic openWindow();
    phaseStart = 1'b1; blockSeen = 1'b1; cyc(); blockSeen = 1'b0;
  endtask

  task automatic runMode(input logic hi, input logic mid, input logic wr,
                         input int d);
    modeHi = hi; modeMid = mid; writeDir = wr; cycleEn = 1'b1;
    openWindow();
    check("R1 phaseOk opens", phaseOk, 1'b1);
    firstByte = 1'b1; cyc(); firstByte = 1'b0;
    check("R3 preamble set", preambleSeen, 1'b1);
    lastByte = 1'b1; cyc(); lastByte = 1'b0;
    check("R3 postamble set", postambleSeen, 1'b1);
    for (int k = 1; k <= d; k++) begin
      cellTick = 1'b1; cyc(); cellTick = 1'b0;
      if (k == d - 1) check("R4 end low one tick early", endOfPost, 1'b0);
      if (k == d) begin
        check("R4 end rises on final tick", endOfPost, 1'b1);
        check("R4 window still open", phaseOk, 1'b1);
      end else begin
        cyc(); cyc();
        if (k == d - 1) check("R5 idle cycles do not count", endOfPost, 1'b0);
      end
    end
    cyc();
    check("R2 end rise closes window", phaseOk, 1'b0);
    cyc();
    check("R3 preamble cleared", preambleSeen, 1'b0);
    check("R3 postamble cleared", postambleSeen, 1'b0);
    check("R6 end holds until clear", endOfPost, 1'b1);
    endClr = 1'b1; cyc();
    check("R6 clear edge drops end", endOfPost, 1'b0);
    endClr = 1'b0; phaseStart = 1'b0; cyc();
  endtask

  initial begin
    repeat (3) cyc();
    rstN = 1'b1; cyc();
    check("R9 reset phaseOk", phaseOk, 1'b0);
    check("R9 reset endOfPost", endOfPost, 1'b0);

    // R3: strobes outside the window ignored
    modeHi = 1'b1; cycleEn = 1'b1;
    firstByte = 1'b1; lastByte = 1'b1; cyc(); firstByte = 1'b0; lastByte = 1'b0;
    check("R3 stray first ignored", preambleSeen, 1'b0);
    check("R3 stray last ignored", postambleSeen, 1'b0);

    // R8: low-density mode
    modeHi = 1'b0; modeMid = 1'b0;
    openWindow(); cyc();
    check("R8 low density no window", phaseOk, 1'b0);
    phaseStart = 1'b0; cyc();

    // R4/R5 full sweep of density and direction
    runMode(1'b1, 1'b0, 1'b1, 34);
    runMode(1'b1, 1'b0, 1'b0, 6);
    runMode(1'b0, 1'b1, 1'b1, 31);
    runMode(1'b0, 1'b1, 1'b0, 21);
    runMode(1'b1, 1'b1, 1'b0, 6);

    // R2: releasing phase sync
    modeHi = 1'b1; writeDir = 1'b0;
    openWindow();
    firstByte = 1'b1; cyc(); firstByte = 1'b0;
    phaseStart = 1'b0; cyc();
    check("R2 phase release closes", phaseOk, 1'b0);
    cyc();
    check("R3 preamble follows close", preambleSeen, 1'b0);

    // R10 / R6: clear edge collides with final tick
    openWindow();
    lastByte = 1'b1; cyc(); lastByte = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      cellTick = 1'b1;
      if (k == 6) endClr = 1'b1;
      cyc(); cellTick = 1'b0;
    end
    check("R10 clear wins collision", endOfPost, 1'b0);
    endClr = 1'b0;
    for (int k = 0; k < 12; k++) begin
      cellTick = 1'b1; cyc(); cellTick = 1'b0; cyc();
    end
    check("R6 no restart of delay", endOfPost, 1'b0);
    check("R10 window stays open", phaseOk, 1'b1);

    // R7: machine cycle off
    syncClear = 1'b1; cyc(); syncClear = 1'b0;
    openWindow();
    lastByte = 1'b1; cyc(); lastByte = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      cellTick = 1'b1; cyc(); cellTick = 1'b0;
    end
    check("R4 end up before gate", endOfPost, 1'b1);
    cycleEn = 1'b0; cyc();
    check("R7 cycle off drops end", endOfPost, 1'b0);
    cycleEn = 1'b1;

    // R9: synchronous clear
    openWindow();
    firstByte = 1'b1; lastByte = 1'b1; cyc(); firstByte = 1'b0; lastByte = 1'b0;
    check("R3 both strobes at once", preambleSeen & postambleSeen, 1'b1);
    syncClear = 1'b1; cyc(); syncClear = 1'b0;
    check("R9 clear phaseOk", phaseOk, 1'b0);
    check("R9 clear preamble", preambleSeen, 1'b0);
    check("R9 clear postamble", postambleSeen, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule